// File: doc/BRIEF.md
# Colour Palette Loader and Lookup

This block holds a 256-entry colour table for a framebuffer controller. Each entry has separate 8-bit red, green and blue components. A bus master writes two word-sized registers. The index register selects the starting entry. The colour data register then takes the components one after another: red first, then green, then blue. A small phase controller remembers which component is due next. After each blue write it moves to the following entry and wraps from 255 back to 0. This lets software reload a run of entries by writing the index once and then streaming triplets.

The scan-out side has its own lookup port. It turns an 8-bit pixel code into a 24-bit colour one clock later. A one-cycle pulse is raised after every colour write, so downstream logic knows to repaint. Reads of the register window always return zero.

Top module: `palette_dac`

## Requirements
- R1: Only byte offset 0 (index register) and byte offset 4 (colour data register) of `wr_addr` are decoded. A write to any other offset changes no table entry, no index and no phase.
- R2: A write to offset 0 loads the current index from `wr_data[31:24]` and sets the phase back to red, even when a triplet is only partly written.
- R3: A write to offset 4 stores `wr_data[31:24]` into one component of the entry at the current index. The component is red in phase 0, green in phase 1 and blue in phase 2, and the phase then moves on to the next value.
- R4: The blue write also increments the current index modulo 256, so 255 is followed by 0, and returns the phase to red.
- R5: `bus_rdata` is zero in every cycle.
- R6: After reset, entries 0 to 254 read as 0x000000 and entry 255 reads as 0xFFFFFF. The index and the phase are cleared, so the first colour write goes to the red component of entry 0.
- R7: `pix_rgb` shows the entry selected by `pix_code` at the previous rising edge. Red is in bits 23:16, green in bits 15:8 and blue in bits 7:0. Both `pix_rgb` and `pal_upd` are 0 in the cycle after a reset edge.
- R8: When a colour write and a lookup hit the same entry at the same edge, the lookup returns the value from before the write.
- R9: `pal_upd` is 1 for exactly the cycle that follows each accepted colour data write, and 0 in every other cycle.
- R10: A component that has not yet been written in a triplet keeps its earlier value, whether that is the reset value or an earlier write.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Byte offset of the write |
| wr_data | input | 32 | Write data; the top byte carries the value |
| bus_rdata | output | 32 | Register read data, always zero |
| pix_code | input | 8 | Pixel code to look up |
| pix_rgb | output | 24 | Colour of the looked-up entry, one cycle later |
| pal_upd | output | 1 | One-cycle pulse after a colour write |

## Verification
A wrong phase or index inside the block does not show up when it goes wrong. It shows up only on the next colour write, which lands in the wrong component or the wrong entry. That error becomes visible on `pix_rgb` one cycle after the affected entry is looked up. For this reason the bench keeps its own behavioural model of the table, the index and the phase. It compares the lookup port and the pulse against that model on every clock while it scans entries. Directed sequences then cover the cases that a broken state machine would get wrong: the wrap at entry 255, a triplet cut short by an index write, writes to undecoded offsets, and a read and write to the same entry at the same edge.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int NUM_COMP = 3;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;
endpackage

// File: rtl/palette_ctl.sv
module palette_ctl
  import palette_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int COMP_W   = 8,
  parameter int BUS_W    = 32,
  parameter int ADDR_W   = 4,
  parameter int IDX_OFS  = 0,
  parameter int DATA_OFS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BUS_W-1:0]    wr_data,
  output logic [IDX_W-1:0]    idx_q,
  output phase_e              phase_q,
  output logic [NUM_COMP-1:0] comp_we,
  output logic [COMP_W-1:0]   comp_val,
  output logic                upd_q
);
  localparam logic [ADDR_W-1:0] OFS_I = ADDR_W'(IDX_OFS);
  localparam logic [ADDR_W-1:0] OFS_D = ADDR_W'(DATA_OFS);
  localparam int LOW_W = BUS_W - ((IDX_W > COMP_W) ? IDX_W : COMP_W);

  logic idx_wr;
  logic data_wr;
  logic unused_low;

  assign idx_wr     = wr_en && (wr_addr == OFS_I);
  assign data_wr    = wr_en && (wr_addr == OFS_D);
  assign comp_val   = wr_data[BUS_W-1 -: COMP_W];
  assign unused_low = ^wr_data[LOW_W-1:0];

  always_comb begin
    comp_we = '0;
    if (data_wr) begin
      case (phase_q)
        PH_RED:  comp_we[0] = 1'b1;
        PH_GRN:  comp_we[1] = 1'b1;
        default: comp_we[2] = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= data_wr;
      if (idx_wr) begin
        idx_q   <= wr_data[BUS_W-1 -: IDX_W];
        phase_q <= PH_RED;
      end else if (data_wr) begin
        case (phase_q)
          PH_RED: phase_q <= PH_GRN;
          PH_GRN: phase_q <= PH_BLU;
          default: begin
            phase_q <= PH_RED;
            idx_q   <= idx_q + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/palette_comp_ram.sv
module palette_comp_ram #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [COMP_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [COMP_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [COMP_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  written;
  logic [COMP_W-1:0] mem_q;
  logic              written_q;
  logic              last_q;

  // Storage array: no reset, read-before-write, suits block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    mem_q <= mem[raddr];
  end

  // Per-entry written flags supply the reset image.
  always_ff @(posedge clk) begin
    if (rst) begin
      written   <= '0;
      written_q <= 1'b0;
      last_q    <= 1'b0;
    end else begin
      if (we) written[waddr] <= 1'b1;
      written_q <= written[raddr];
      last_q    <= (raddr == LAST);
    end
  end

  always_comb begin
    if (written_q)   rdata = mem_q;
    else if (last_q) rdata = '1;
    else             rdata = '0;
  end
endmodule

// File: rtl/palette_dac.sv
module palette_dac
  import palette_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int COMP_W   = 8,
  parameter int BUS_W    = 32,
  parameter int ADDR_W   = 4,
  parameter int IDX_OFS  = 0,
  parameter int DATA_OFS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [BUS_W-1:0]           wr_data,
  output logic [BUS_W-1:0]           bus_rdata,
  input  logic [IDX_W-1:0]           pix_code,
  output logic [NUM_COMP*COMP_W-1:0] pix_rgb,
  output logic                       pal_upd
);
  logic [IDX_W-1:0]    cur_idx;
  phase_e              cur_phase;
  logic [NUM_COMP-1:0] comp_we;
  logic [COMP_W-1:0]   comp_val;
  logic [COMP_W-1:0]   comp_rd [NUM_COMP];

  assign bus_rdata = '0;

  palette_ctl #(
    .IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
    .IDX_OFS(IDX_OFS), .DATA_OFS(DATA_OFS)
  ) u_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .idx_q(cur_idx), .phase_q(cur_phase), .comp_we(comp_we),
    .comp_val(comp_val), .upd_q(pal_upd)
  );

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    palette_comp_ram #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_ram (
      .clk(clk), .rst(rst), .we(comp_we[c]), .waddr(cur_idx),
      .wdata(comp_val), .raddr(pix_code), .rdata(comp_rd[c])
    );
    // Component 0 (red) lands in the most significant slot.
    assign pix_rgb[(NUM_COMP-c)*COMP_W-1 -: COMP_W] = comp_rd[c];
  end
endmodule

// File: rtl/palette_dac_chk.sv
module palette_dac_chk #(
  parameter int IDX_W    = 8,
  parameter int BUS_W    = 32,
  parameter int ADDR_W   = 4,
  parameter int IDX_OFS  = 0,
  parameter int DATA_OFS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BUS_W-1:0]  wr_data,
  input logic [IDX_W-1:0]  idx,
  input logic [1:0]        phase,
  input logic [2:0]        comp_we,
  input logic              pal_upd
);
  logic is_idx, is_data;
  assign is_idx  = wr_en && (wr_addr == ADDR_W'(IDX_OFS));
  assign is_data = wr_en && (wr_addr == ADDR_W'(DATA_OFS));

  p_ignore_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !is_idx && !is_data) |=> ($stable(idx) && $stable(phase)));

  p_idx_load_r2: assert property (@(posedge clk) disable iff (rst)
    is_idx |=> (idx == $past(wr_data[BUS_W-1 -: IDX_W]) && phase == 2'd0));

  p_phase_legal_r3: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd3);

  p_one_comp_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(comp_we));

  p_red_to_green_r3: assert property (@(posedge clk) disable iff (rst)
    (is_data && phase == 2'd0) |=> (phase == 2'd1 && $stable(idx)));

  p_idx_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (is_data && phase == 2'd2) |=> (idx == IDX_W'($past(idx) + 1'b1) && phase == 2'd0));

  p_upd_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    is_data |=> pal_upd);

  p_upd_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !is_data |=> !pal_upd);
endmodule

bind palette_dac palette_dac_chk #(
  .IDX_W(IDX_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
  .IDX_OFS(IDX_OFS), .DATA_OFS(DATA_OFS)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .idx(cur_idx), .phase(cur_phase), .comp_we(comp_we), .pal_upd(pal_upd)
);

// File: tb/tb_palette_dac.sv
module tb_palette_dac;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_code = '0;
  logic [23:0] pix_rgb;
  logic        pal_upd;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  bit armed = 0;

  // behavioural reference model
  int mr [256];
  int mg [256];
  int mb [256];
  int midx = 0;
  int mph = 0;
  logic [23:0] exp_rgb = '0;
  logic        exp_upd = 1'b0;

  always #2 clk = ~clk;

  palette_dac dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bus_rdata(bus_rdata), .pix_code(pix_code), .pix_rgb(pix_rgb), .pal_upd(pal_upd)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    armed = 1;
    if (rst) begin
      for (int i = 0; i < 256; i++) begin
        mr[i] = (i == 255) ? 255 : 0;
        mg[i] = mr[i];
        mb[i] = mr[i];
      end
      midx = 0; mph = 0; exp_rgb = '0; exp_upd = 1'b0;
    end else begin
      exp_rgb = {8'(mr[pix_code]), 8'(mg[pix_code]), 8'(mb[pix_code])};
      exp_upd = wr_en && (wr_addr == 4'd4);
      if (wr_en && wr_addr == 4'd0) begin
        midx = wr_data[31:24]; mph = 0;
      end else if (wr_en && wr_addr == 4'd4) begin
        if (mph == 0) mr[midx] = wr_data[31:24];
        else if (mph == 1) mg[midx] = wr_data[31:24];
        else mb[midx] = wr_data[31:24];
        if (mph == 2) begin midx = (midx + 1) % 256; mph = 0; end
        else mph++;
      end
    end
  end

  // Per-clock comparison against the model (R7, R9, R5)
  always @(negedge clk) begin
    if (armed && !done) begin
      chk("R7 model lookup", {8'h0, pix_rgb}, {8'h0, exp_rgb});
      chk("R9 model pulse", {31'h0, pal_upd}, {31'h0, exp_upd});
      chk("R5 read data", bus_rdata, 32'h0);
    end
  end

  task automatic bus_wr(logic [3:0] a, logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = {v, 24'h5A5A5A};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(logic [7:0] code, logic [23:0] exp, string tag);
    @(negedge clk);
    pix_code = code;
    @(negedge clk);
    chk(tag, {8'h0, pix_rgb}, {8'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R7 reset output", {8'h0, pix_rgb}, 32'h0);
    look(8'd0,   24'h000000, "R6 entry 0 black");
    look(8'd255, 24'hFFFFFF, "R6 entry 255 white");
    look(8'd128, 24'h000000, "R6 entry 128 black");
    // R6: first colour write after reset goes to red of entry 0
    bus_wr(4'd4, 8'h9A);
    chk("R9 pulse after write", {31'h0, pal_upd}, 32'h1);
    @(negedge clk);
    chk("R9 pulse ends", {31'h0, pal_upd}, 32'h0);
    look(8'd0, 24'h9A0000, "R6 cleared index/phase, R10");
    // R3 full triplet, then R4 advance
    bus_wr(4'd0, 8'h10);
    bus_wr(4'd4, 8'hAA); bus_wr(4'd4, 8'hBB); bus_wr(4'd4, 8'hCC);
    look(8'h10, 24'hAABBCC, "R3 triplet");
    bus_wr(4'd4, 8'h11);
    look(8'h11, 24'h110000, "R4 index advance");
    // R4 wrap
    bus_wr(4'd0, 8'hFF);
    bus_wr(4'd4, 8'h01); bus_wr(4'd4, 8'h02); bus_wr(4'd4, 8'h03);
    bus_wr(4'd4, 8'h44);
    look(8'hFF, 24'h010203, "R4 entry 255 written");
    look(8'h00, 24'h440000, "R4 wrap to 0");
    // R1 undecoded offsets ignored mid-triplet
    bus_wr(4'd0, 8'h20);
    bus_wr(4'd4, 8'h12);
    bus_wr(4'd8, 8'hEE);
    bus_wr(4'd12, 8'hDD);
    bus_wr(4'd2, 8'hCC);
    look(8'h20, 24'h120000, "R1 ignored offsets");
    bus_wr(4'd4, 8'h34); bus_wr(4'd4, 8'h56);
    look(8'h20, 24'h123456, "R1 phase kept");
    look(8'hEE, 24'h000000, "R1 no stray entry");
    // R2 index write cuts a triplet short; R10 partial entry
    bus_wr(4'd0, 8'h30);
    bus_wr(4'd4, 8'h77);
    bus_wr(4'd0, 8'h31);
    bus_wr(4'd4, 8'h88);
    look(8'h30, 24'h770000, "R10 partial entry");
    look(8'h31, 24'h880000, "R2 phase reset");
    // R8 same-edge write and lookup
    bus_wr(4'd0, 8'h40);
    bus_wr(4'd4, 8'h11); bus_wr(4'd4, 8'h22);
    @(negedge clk);
    pix_code = 8'h40; wr_en = 1'b1; wr_addr = 4'd4; wr_data = 32'h33000000;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 old value", {8'h0, pix_rgb}, 32'h00112200);
    @(negedge clk);
    chk("R8 new value", {8'h0, pix_rgb}, 32'h00112233);
    // R6 reset again restores the image
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    look(8'h10, 24'h000000, "R6 reset clears entry");
    look(8'hFF, 24'hFFFFFF, "R6 reset white entry");
    // sweep every entry against the model
    for (int k = 0; k < 256; k++) begin
      @(negedge clk); pix_code = 8'(k);
    end
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule